// File: doc/BRIEF.md
# Temperature Alert Control and Status Register

This block is the digital side of an on-chip temperature monitor. It holds two 8-bit registers behind a simple synchronous register port. The control/status register drives the sensor enable and the selection of what feeds the ADC channel. It shows the live high-temperature status from the analog comparator and keeps a sticky change flag that can raise an interrupt. The trim register holds an offset-enable bit and a 4-bit offset code, both passed straight to the analog front end.

The comparator output arrives asynchronously. It passes through a synchronizer chain. A change detector compares the synchronized value with its value one clock earlier. The sticky flag is a two-state machine. In state FLG_IDLE the flag reads 0, and the transition SET_ON_CHANGE moves it to FLG_PEND. In state FLG_PEND the flag reads 1. The transition CLEAR_ON_W1C returns it to FLG_IDLE, but only when no new change arrives in the same cycle. Any other combination keeps the current state (HOLD).

Register writes take effect at the clock edge on which the write strobe is high. Reads are combinational from the address.

Top module: `tmon_alert_csr`

## Requirements
- R1: After reset, both registers read 0x00, and sens_en, adc_sel_bg, irq, trim_en and trim_code are all 0.
- R2: In the control register (address 0), bit 3 is the sensor enable and bit 1 is the interrupt enable. Both are written by a register write and read back unchanged. sens_en follows bit 3.
- R3: Control register bits 7..5 always read 0, and writes to them have no effect.
- R4: Control register bit 2 shows the comparator input delayed by the two-flop synchronizer. After the input changes, two rising clock edges pass before bit 2 shows the new value. Writes to bit 2 have no effect.
- R5: Control register bit 0 (the flag) becomes 1 on the rising edge after bit 2 changes value, in either direction. That is the third edge after the input change. Without a change it never sets by itself.
- R6: Writing 1 to bit 0 clears the flag. Writing 0 to bit 0 leaves it unchanged.
- R7: If a status change and a write of 1 to bit 0 fall on the same edge, the flag ends up 1.
- R8: irq is 1 exactly when the flag is 1 and the interrupt enable bit is 1.
- R9: The trim register (address 1) stores bit 7 (offset enable) and bits 3..0 (offset code). These drive trim_en and trim_code. Bits 6..4 read 0.
- R10: Bit 4 of the control register is the ADC source select (0 = sensor, 1 = bandgap). It reads back as written. adc_sel_bg is 1 only when both bit 4 and bit 3 are 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_addr | input | 1 | Register select: 0 control/status, 1 trim |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for reg_addr |
| hot_in | input | 1 | Asynchronous comparator output, 1 = above alert level |
| sens_en | output | 1 | Temperature sensor enable |
| adc_sel_bg | output | 1 | ADC channel takes the bandgap when 1 |
| irq | output | 1 | Interrupt request |
| trim_en | output | 1 | Offset trim enable |
| trim_code | output | 4 | Offset trim code |

## Verification
The assertions assume that hot_in changes no more often than once every three clocks. Each change then reaches the flag as its own event. The assertions also assume that reset is applied before any write.

The stimulus changes hot_in only on falling clock edges, and at least three rising edges apart. It keeps hot_in stable during register sweeps, so that the readback of bit 2 and bit 0 stays predictable. Writes to the control register are swept over all 256 values, and so are writes to the trim register.

// File: rtl/tmon_pkg.sv
package tmon_pkg;
    localparam int DATA_W   = 8;
    localparam int TRIM_W   = 4;
    // control/status bit positions
    localparam int B_FLAG   = 0;
    localparam int B_IE     = 1;
    localparam int B_STAT   = 2;
    localparam int B_SENS   = 3;
    localparam int B_SEL    = 4;
    // trim register bit position of the enable
    localparam int B_TEN    = 7;
    localparam logic ADDR_CTRL = 1'b0;
    localparam logic ADDR_TRIM = 1'b1;

    typedef enum logic {
        FLG_IDLE = 1'b0,
        FLG_PEND = 1'b1
    } flag_state_e;

    typedef struct packed {
        logic sel_bg;
        logic sens;
        logic ie;
    } ctrl_t;
endpackage

// File: rtl/tmon_sync.sv
module tmon_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_in,
    output logic q_out
);
    logic [STAGES-1:0] chain_q;

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain_q[0] <= 1'b0;
                    else        chain_q[0] <= d_in;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain_q[s] <= 1'b0;
                    else        chain_q[s] <= chain_q[s-1];
                end
            end
        end
    endgenerate

    assign q_out = chain_q[STAGES-1];
endmodule

// File: rtl/tmon_flag_fsm.sv
module tmon_flag_fsm
    import tmon_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic status,
    input  logic clr_req,
    output logic change,
    output logic flag_o
);
    flag_state_e state_q, state_d;
    logic        prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= status;
    end

    assign change = status ^ prev_q;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= FLG_IDLE;
        else        state_q <= state_d;
    end

    // transitions: SET_ON_CHANGE, CLEAR_ON_W1C, HOLD
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            FLG_IDLE: if (change) state_d = FLG_PEND;
            FLG_PEND: if (clr_req && !change) state_d = FLG_IDLE;
            default:  state_d = FLG_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        unique case (state_q)
            FLG_PEND: flag_o = 1'b1;
            default:  flag_o = 1'b0;
        endcase
    end

    a_r5_sets_on_change: assert property (@(posedge clk) disable iff (!rst_n)
        change |=> flag_o);
    a_r5_no_spurious_set: assert property (@(posedge clk) disable iff (!rst_n)
        (!flag_o && !change) |=> !flag_o);
    a_r6_w1c_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_o && clr_req && !change) |=> !flag_o);
    a_r7_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_req && change) |=> flag_o);
endmodule

// File: rtl/tmon_regs.sv
module tmon_regs
    import tmon_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              addr,
    input  logic              wr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              status,
    input  logic              flag,
    output logic [DATA_W-1:0] rdata,
    output ctrl_t             ctrl,
    output logic              clr_req,
    output logic              trim_en,
    output logic [TRIM_W-1:0] trim_code
);
    ctrl_t             ctrl_q;
    logic              ten_q;
    logic [TRIM_W-1:0] tcode_q;
    logic              wr_ctrl, wr_trim;

    assign wr_ctrl = wr && (addr == ADDR_CTRL);
    assign wr_trim = wr && (addr == ADDR_TRIM);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q <= '0;
        end else if (wr_ctrl) begin
            ctrl_q.sel_bg <= wdata[B_SEL];
            ctrl_q.sens   <= wdata[B_SENS];
            ctrl_q.ie     <= wdata[B_IE];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ten_q   <= 1'b0;
            tcode_q <= '0;
        end else if (wr_trim) begin
            ten_q   <= wdata[B_TEN];
            tcode_q <= wdata[TRIM_W-1:0];
        end
    end

    assign clr_req = wr_ctrl && wdata[B_FLAG];

    always_comb begin
        rdata = '0;
        if (addr == ADDR_CTRL) begin
            rdata[B_SEL]  = ctrl_q.sel_bg;
            rdata[B_SENS] = ctrl_q.sens;
            rdata[B_STAT] = status;
            rdata[B_IE]   = ctrl_q.ie;
            rdata[B_FLAG] = flag;
        end else begin
            rdata[B_TEN]        = ten_q;
            rdata[TRIM_W-1:0]   = tcode_q;
        end
    end

    assign ctrl      = ctrl_q;
    assign trim_en   = ten_q;
    assign trim_code = tcode_q;

    a_r2_ie_written: assert property (@(posedge clk) disable iff (!rst_n)
        wr_ctrl |=> (ctrl.ie == $past(wdata[B_IE])));
    a_r9_trim_written: assert property (@(posedge clk) disable iff (!rst_n)
        wr_trim |=> (trim_code == $past(wdata[TRIM_W-1:0])));
    a_r9_trim_held: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_trim |=> $stable(trim_code) && $stable(trim_en));
endmodule

// File: rtl/tmon_alert_csr.sv
module tmon_alert_csr
    import tmon_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        reg_addr,
    input  logic        reg_wr,
    input  logic [7:0]  reg_wdata,
    output logic [7:0]  reg_rdata,
    input  logic        hot_in,
    output logic        sens_en,
    output logic        adc_sel_bg,
    output logic        irq,
    output logic        trim_en,
    output logic [3:0]  trim_code
);
    logic  status_s;
    logic  change_s;
    logic  flag_s;
    logic  clr_s;
    ctrl_t ctrl_s;

    tmon_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_in  (hot_in),
        .q_out (status_s)
    );

    tmon_flag_fsm u_flag (
        .clk     (clk),
        .rst_n   (rst_n),
        .status  (status_s),
        .clr_req (clr_s),
        .change  (change_s),
        .flag_o  (flag_s)
    );

    tmon_regs u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .addr      (reg_addr),
        .wr        (reg_wr),
        .wdata     (reg_wdata),
        .status    (status_s),
        .flag      (flag_s),
        .rdata     (reg_rdata),
        .ctrl      (ctrl_s),
        .clr_req   (clr_s),
        .trim_en   (trim_en),
        .trim_code (trim_code)
    );

    assign sens_en    = ctrl_s.sens;
    assign adc_sel_bg = ctrl_s.sens && ctrl_s.sel_bg;
    assign irq        = flag_s && ctrl_s.ie;

    a_r8_irq_needs_flag: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (flag_s && ctrl_s.ie));
    a_r10_sel_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
        adc_sel_bg |-> sens_en);
endmodule

// File: tb/tmon_alert_csr_tb_top.sv
module tmon_alert_csr_tb_top;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       reg_addr = 1'b0;
    logic       reg_wr = 1'b0;
    logic [7:0] reg_wdata = 8'h00;
    logic [7:0] reg_rdata;
    logic       hot_in = 1'b0;
    logic       sens_en, adc_sel_bg, irq, trim_en;
    logic [3:0] trim_code;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    tmon_alert_csr dut_i (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .hot_in(hot_in),
        .sens_en(sens_en), .adc_sel_bg(adc_sel_bg), .irq(irq),
        .trim_en(trim_en), .trim_code(trim_code)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %02h expected %02h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic wr(input logic a, input logic [7:0] d);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        tick();
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic a, output logic [7:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    function automatic logic [7:0] exp_ctrl(input logic [7:0] d, input logic st, input logic fl);
        return {3'b000, d[4], d[3], st, d[1], fl};
    endfunction

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [7:0] r;
        logic       cur_hot;
        logic [7:0] pat;
        cur_hot = 1'b0;
        pat = 8'b1011_0110;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        rd(1'b0, r); check("R1 ctrl reset", r, 8'h00);
        rd(1'b1, r); check("R1 trim reset", r, 8'h00);
        check("R1 outputs", {3'b0, sens_en, adc_sel_bg, irq, trim_en, 1'b0}, 8'h00);
        check("R1 trim_code", {4'h0, trim_code}, 8'h00);

        // R2 R3 R4 R10 sweep control register (status 0, flag 0)
        for (int d = 0; d < 256; d++) begin
            wr(1'b0, d[7:0]);
            rd(1'b0, r);
            check("R2 R3 R4 R10 ctrl readback", r, exp_ctrl(d[7:0], 1'b0, 1'b0));
            check("R2 sens_en", {7'b0, sens_en}, {7'b0, d[3]});
            check("R10 adc_sel_bg", {7'b0, adc_sel_bg}, {7'b0, d[3] & d[4]});
        end

        // R9 sweep trim register
        for (int d = 0; d < 256; d++) begin
            wr(1'b1, d[7:0]);
            rd(1'b1, r);
            check("R9 trim readback", r, {d[7], 3'b000, d[3:0]});
            check("R9 trim outputs", {trim_en, 3'b000, trim_code}, {d[7], 3'b000, d[3:0]});
        end

        // R4 R5 R6 R8 status pattern walk, ie=1 sensor on
        wr(1'b0, 8'h0B);
        for (int i = 0; i < 8; i++) begin
            logic v;
            v = pat[i];
            hot_in = v;
            tick(); tick();
            rd(1'b0, r);
            check("R4 status after two edges", {7'b0, r[2]}, {7'b0, v});
            check("R5 flag not yet set", {7'b0, r[0]}, 8'h00);
            tick();
            rd(1'b0, r);
            check("R5 flag on change", {7'b0, r[0]}, {7'b0, v ^ cur_hot});
            check("R8 irq follows flag", {7'b0, irq}, {7'b0, v ^ cur_hot});
            wr(1'b0, 8'h0B);
            rd(1'b0, r);
            check("R6 w1c clears", {7'b0, r[0]}, 8'h00);
            cur_hot = v;
        end

        // produce flag=1 then test write 0 and ie gating
        hot_in = ~cur_hot; cur_hot = ~cur_hot;
        tick(); tick(); tick();
        wr(1'b0, 8'h0A);
        rd(1'b0, r);
        check("R6 write 0 keeps flag", {7'b0, r[0]}, 8'h01);
        wr(1'b0, 8'h08);
        check("R8 irq off when ie=0", {7'b0, irq}, 8'h00);
        wr(1'b0, 8'h0E);
        rd(1'b0, r);
        check("R4 write to status ignored", {7'b0, r[2]}, {7'b0, cur_hot});
        check("R8 irq on when ie=1", {7'b0, irq}, 8'h01);

        // R7 change and w1c on the same edge
        hot_in = ~cur_hot; cur_hot = ~cur_hot;
        tick(); tick();
        wr(1'b0, 8'h0B);
        rd(1'b0, r);
        check("R7 set wins over clear", {7'b0, r[0]}, 8'h01);
        wr(1'b0, 8'h0B);
        rd(1'b0, r);
        check("R6 clear afterwards", {7'b0, r[0]}, 8'h00);
        repeat (5) tick();
        rd(1'b0, r);
        check("R5 no spurious set", {7'b0, r[0]}, 8'h00);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule